// File: doc/BRIEF.md
# Local-History Branch Predictor Table

This block is a direct-mapped table of conditional-branch records that a fetch stage consults for every fetched instruction address. Each record belongs to one branch. It holds an address tag, a valid flag, a short shift register of that branch's own recent outcomes and the address the branch last jumped to. A lookup is purely combinational. In the same cycle that an address is presented, the block reports whether a record exists for it, the taken or not-taken guess and the stored destination. When there is no record, the block falls back to a fixed guess of not taken.

When a branch resolves, the execute stage presents its address, its real outcome and its real destination on the update port. The block then trains the matching record. If no record matches, it overwrites whatever record sits at that slot. The guess comes from a vote over the outcome bits of the record. Outcomes of different branches never mix, so each branch keeps its own pattern.

The update process classifies each resolved branch into one of three actions: UPD_IDLE (no update presented), UPD_ALLOC (slot empty or held by another branch, so a fresh record is written) and UPD_TRAIN (the record belongs to this branch, so its outcome bits shift). From UPD_IDLE, a valid update goes to UPD_ALLOC on a tag mismatch or an empty slot, and to UPD_TRAIN on a tag match. Every action lasts one cycle and falls back to UPD_IDLE.

Top module: `bht_local_pred`

## Requirements
- R1: After reset every slot is empty, so every lookup reports no hit and a not-taken guess until an update has written a record.
- R2: The slot is selected by address bits [5:2] (16 slots) and the tag is address bits [31:6]. A lookup hits only when the slot is valid and its tag equals the tag of the looked-up address, and the result appears in the same cycle as the address.
- R3: On a lookup miss, pred_hit, pred_taken and pred_target are all 0.
- R4: An update whose address misses writes the slot with valid set, the new tag and the update target, and fills all 4 outcome bits with the actual outcome (1 = taken). An all-ones record guesses taken and an all-zeros record guesses not taken.
- R5: An update whose address hits shifts the outcome bits left by one, drops the oldest bit (bit 3) and places the new outcome in bit 0.
- R6: On a hit, pred_taken is 1 exactly when at least 3 of the 4 outcome bits are 1. Two ones out of four guess not taken.
- R7: On an update that hits, the stored target is replaced by the update target only when the outcome is taken. A not-taken outcome leaves the target unchanged.
- R8: Two branches that share a slot but differ in tag evict each other. After the second one is written, the first one misses.
- R9: When a lookup and an update fall in the same cycle on the same slot, the lookup reports the contents from before the update. The new contents are visible from the next cycle.
- R10: An update changes only the slot selected by its own address. Records in other slots keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 32 | Address being looked up |
| pred_hit | output | 1 | A valid record matches lk_pc |
| pred_taken | output | 1 | Guess: 1 = taken |
| pred_target | output | 32 | Stored destination on a hit, 0 otherwise |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_target | input | 32 | Real destination of the branch |

## Verification
A lookup and an update can fall in the same cycle. The case that matters is when both select the same slot, either for the same branch or for an aliasing one. The bench provokes this by presenting an update together with a lookup of the same address, and later a lookup of an aliasing address. The scoreboard expects the contents from before the write in that cycle, and the new contents in the following cycle. A random phase then mixes lookups and updates over a few colliding slots, so that these collisions recur many times.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

    // Action taken by the update side in one cycle.
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_ALLOC = 2'd1,
        UPD_TRAIN = 2'd2
    } upd_kind_e;

endpackage

// File: rtl/bhp_entry_array.sv
module bhp_entry_array #(
    parameter int N_ENT  = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    parameter int HIST_W = 4,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [HIST_W-1:0] wr_hist,
    input  logic [PC_W-1:0]   wr_tgt,
    input  logic [IDX_W-1:0]  a_idx,
    output logic              a_valid,
    output logic [TAG_W-1:0]  a_tag,
    output logic [HIST_W-1:0] a_hist,
    output logic [PC_W-1:0]   a_tgt,
    input  logic [IDX_W-1:0]  b_idx,
    output logic              b_valid,
    output logic [TAG_W-1:0]  b_tag,
    output logic [HIST_W-1:0] b_hist,
    output logic [PC_W-1:0]   b_tgt
);

    logic              val_q  [N_ENT];
    logic [TAG_W-1:0]  tag_q  [N_ENT];
    logic [HIST_W-1:0] hist_q [N_ENT];
    logic [PC_W-1:0]   tgt_q  [N_ENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENT; e++) begin
                val_q[e]  <= 1'b0;
                tag_q[e]  <= '0;
                hist_q[e] <= '0;
                tgt_q[e]  <= '0;
            end
        end else if (wr_en) begin
            for (int e = 0; e < N_ENT; e++) begin
                if (wr_idx == IDX_W'(e)) begin
                    val_q[e]  <= 1'b1;
                    tag_q[e]  <= wr_tag;
                    hist_q[e] <= wr_hist;
                    tgt_q[e]  <= wr_tgt;
                end
            end
        end
    end

    // Lookup side read port
    always_comb begin
        a_valid = val_q[a_idx];
        a_tag   = tag_q[a_idx];
        a_hist  = hist_q[a_idx];
        a_tgt   = tgt_q[a_idx];
    end

    // Update side read port
    always_comb begin
        b_valid = val_q[b_idx];
        b_tag   = tag_q[b_idx];
        b_hist  = hist_q[b_idx];
        b_tgt   = tgt_q[b_idx];
    end

endmodule

// File: rtl/bhp_vote.sv
module bhp_vote #(
    parameter int HIST_W = 4
) (
    input  logic [HIST_W-1:0] hist,
    output logic              taken
);

    localparam int CNT_W = $clog2(HIST_W + 1);
    localparam int HALF  = HIST_W / 2;

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int b = 0; b < HIST_W; b++) begin
            ones = ones + CNT_W'(hist[b]);
        end
        // strict majority; a tie guesses not taken
        taken = (ones > CNT_W'(HALF));
    end

endmodule

// File: rtl/bhp_upd_ctl.sv
module bhp_upd_ctl
    import bhp_pkg::*;
#(
    parameter int TAG_W  = 26,
    parameter int HIST_W = 4,
    parameter int PC_W   = 32
) (
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [PC_W-1:0]   upd_tgt,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [HIST_W-1:0] ent_hist,
    input  logic [PC_W-1:0]   ent_tgt,
    output upd_kind_e         kind,
    output logic              wr_en,
    output logic [HIST_W-1:0] wr_hist,
    output logic [PC_W-1:0]   wr_tgt
);

    // Classify the resolved branch
    always_comb begin
        kind = UPD_IDLE;
        if (upd_valid) begin
            if (ent_valid && (ent_tag == upd_tag)) kind = UPD_TRAIN;
            else                                   kind = UPD_ALLOC;
        end
    end

    // Produce the write data for the chosen action
    always_comb begin
        wr_en   = 1'b0;
        wr_hist = ent_hist;
        wr_tgt  = ent_tgt;
        unique case (kind)
            UPD_IDLE: begin
                wr_en = 1'b0;
            end
            UPD_ALLOC: begin
                wr_en   = 1'b1;
                wr_hist = {HIST_W{upd_taken}};
                wr_tgt  = upd_tgt;
            end
            UPD_TRAIN: begin
                wr_en   = 1'b1;
                wr_hist = {ent_hist[HIST_W-2:0], upd_taken};
                wr_tgt  = upd_taken ? upd_tgt : ent_tgt;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bht_local_pred.sv
module bht_local_pred
    import bhp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int HIST_W  = 4,
    parameter int ALIGN_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    localparam int N_ENT   = 1 << IDX_W;
    localparam int TAG_LSB = IDX_W + ALIGN_W;
    localparam int TAG_W   = PC_W - TAG_LSB;

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              a_valid, b_valid;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [HIST_W-1:0] a_hist, b_hist;
    logic [PC_W-1:0]   a_tgt, b_tgt;
    logic              vote_taken;
    logic              lk_match;
    upd_kind_e         upd_kind;
    logic              wr_en;
    logic [HIST_W-1:0] wr_hist;
    logic [PC_W-1:0]   wr_tgt;
    logic              unused_align_bits;

    assign lk_idx = lk_pc[TAG_LSB-1:ALIGN_W];
    assign lk_tag = lk_pc[PC_W-1:TAG_LSB];
    assign up_idx = upd_pc[TAG_LSB-1:ALIGN_W];
    assign up_tag = upd_pc[PC_W-1:TAG_LSB];
    assign unused_align_bits = ^{lk_pc[ALIGN_W-1:0], upd_pc[ALIGN_W-1:0]};

    bhp_entry_array #(
        .N_ENT (N_ENT),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .HIST_W(HIST_W),
        .PC_W  (PC_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (up_idx),
        .wr_tag (up_tag),
        .wr_hist(wr_hist),
        .wr_tgt (wr_tgt),
        .a_idx  (lk_idx),
        .a_valid(a_valid),
        .a_tag  (a_tag),
        .a_hist (a_hist),
        .a_tgt  (a_tgt),
        .b_idx  (up_idx),
        .b_valid(b_valid),
        .b_tag  (b_tag),
        .b_hist (b_hist),
        .b_tgt  (b_tgt)
    );

    bhp_vote #(
        .HIST_W(HIST_W)
    ) u_vote (
        .hist (a_hist),
        .taken(vote_taken)
    );

    bhp_upd_ctl #(
        .TAG_W (TAG_W),
        .HIST_W(HIST_W),
        .PC_W  (PC_W)
    ) u_upd (
        .upd_valid(upd_valid),
        .upd_taken(upd_taken),
        .upd_tag  (up_tag),
        .upd_tgt  (upd_target),
        .ent_valid(b_valid),
        .ent_tag  (b_tag),
        .ent_hist (b_hist),
        .ent_tgt  (b_tgt),
        .kind     (upd_kind),
        .wr_en    (wr_en),
        .wr_hist  (wr_hist),
        .wr_tgt   (wr_tgt)
    );

    // Lookup outputs: static not-taken fallback on a miss
    always_comb begin
        lk_match    = a_valid && (a_tag == lk_tag);
        pred_hit    = lk_match;
        pred_taken  = lk_match && vote_taken;
        pred_target = lk_match ? a_tgt : '0;
    end

endmodule

// File: rtl/bhp_chk.sv
module bhp_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_target,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target
);

    logic any_upd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         any_upd_q <= 1'b0;
        else if (upd_valid) any_upd_q <= 1'b1;
    end

    AST_COLD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !any_upd_q |-> !pred_hit); // R1

    AST_MISS_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (!pred_taken && pred_target == '0)); // R3

    AST_WRITTEN_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (lk_pc != $past(upd_pc) || pred_hit)); // R4

    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            (lk_pc != $past(upd_pc) || pred_target == $past(upd_target))); // R7

    AST_GUESS_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit); // R6

endmodule

bind bht_local_pred bhp_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_pc      (lk_pc),
    .pred_hit   (pred_hit),
    .pred_taken (pred_taken),
    .pred_target(pred_target),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_target (upd_target)
);

// File: tb/bht_local_pred_tb.sv
module bht_local_pred_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    always #5 clk = ~clk;

    bht_local_pred u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    // Reference state built from the requirements
    logic        m_v [N];
    logic [25:0] m_tag [N];
    logic [3:0]  m_h [N];
    logic [31:0] m_t [N];

    typedef struct {
        string       req;
        logic        hit;
        logic        tk;
        logic [31:0] tgt;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_h[i] = '0; m_t[i] = '0;
        end
    endtask

    // Driver: one cycle of stimulus, pushes the expected lookup result
    task automatic step(string req, logic [31:0] lpc, logic uv,
                        logic [31:0] upc, logic ut, logic [31:0] utg);
        exp_t x;
        int li, ui;
        @(posedge clk);
        #1;
        lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
        li = int'(lpc[5:2]);
        x.req = req;
        x.hit = m_v[li] && (m_tag[li] == lpc[31:6]);
        x.tk  = x.hit && ($countones(m_h[li]) >= 3);
        x.tgt = x.hit ? m_t[li] : 32'h0;
        q.push_back(x);
        if (uv) begin
            ui = int'(upc[5:2]);
            if (m_v[ui] && m_tag[ui] == upc[31:6]) begin
                m_h[ui] = {m_h[ui][2:0], ut};
                if (ut) m_t[ui] = utg;
            end else begin
                m_v[ui] = 1'b1; m_tag[ui] = upc[31:6];
                m_h[ui] = {4{ut}}; m_t[ui] = utg;
            end
        end
    endtask

    task automatic look(string req, logic [31:0] lpc);
        step(req, lpc, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0; upd_valid = 1'b0;
        model_clear();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Monitor: compares outputs mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            checks++;
            if (pred_hit !== x.hit || pred_taken !== x.tk || pred_target !== x.tgt) begin
                fails++;
                $display("FAIL %s: actual hit=%0b taken=%0b target=%h expected hit=%0b taken=%0b target=%h",
                         x.req, pred_hit, pred_taken, pred_target, x.hit, x.tk, x.tgt);
            end
        end
    end

    function automatic logic [31:0] pick(int t, int i);
        return 32'(((t + 1) << 6) | (i << 2));
    endfunction

    localparam logic [31:0] PA = 32'h0000_1004; // slot 1
    localparam logic [31:0] PB = 32'h0000_1044; // slot 1, other tag
    localparam logic [31:0] PC = 32'h0000_2008; // slot 2

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: every slot empty after reset
        for (int i = 0; i < N; i++) look("R1", 32'(i << 2) | 32'h0000_4000);
        // R2: same-cycle lookup, miss before any write; R3 fallback values
        look("R2", PA);
        // R9: update and lookup together see old (empty) contents
        step("R9", PA, 1'b1, PA, 1'b1, 32'h0000_3000);
        // R4: allocated taken record guesses taken with its target
        look("R4", PA);
        // R9: not-taken training, same cycle still shows 1111
        step("R9", PA, 1'b1, PA, 1'b0, 32'h0000_5555);
        // R5: 1110 still taken; train not taken -> 1100
        step("R5", PA, 1'b1, PA, 1'b0, 32'h0000_6666);
        // R6: 1100 tie -> not taken; R7 target kept at 3000
        look("R6", PA);
        look("R7", PA);
        step("R7", PA, 1'b1, PA, 1'b1, 32'h0000_4000); // -> 1001
        look("R7", PA);                                 // target 4000, not taken
        step("R5", PA, 1'b1, PA, 1'b1, 32'h0000_4000); // -> 0011
        step("R6", PA, 1'b1, PA, 1'b1, 32'h0000_4000); // 0011 not taken, -> 0111
        look("R6", PA);                                 // 3 ones -> taken
        look("R3", PC);                                 // empty slot 2
        look("R2", PB);                                 // same slot, other tag misses
        // R8: aliasing branch evicts
        step("R9", PB, 1'b1, PB, 1'b0, 32'h0000_7000);
        look("R8", PA);
        look("R4", PB);
        // R10: write to slot 2 leaves slot 1 alone
        step("R10", PB, 1'b1, PC, 1'b1, 32'h0000_8000);
        look("R10", PB);
        look("R10", PC);

        // R1: reset again wipes the table
        do_reset();
        look("R1", PB);
        look("R1", PC);

        // R10: mixed random traffic over colliding slots
        for (int k = 0; k < 400; k++) begin
            step("R10",
                 pick(int'($urandom_range(0, 1)), int'($urandom_range(0, 2))),
                 1'($urandom_range(0, 1)),
                 pick(int'($urandom_range(0, 1)), int'($urandom_range(0, 2))),
                 1'($urandom_range(0, 1)),
                 32'($urandom));
        end
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual run still active expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule